// File: doc/BRIEF.md
# Dual-Path Locking-Aid Loop Filter

This block is the digital loop filter of a bang-bang digital PLL. It runs on the reference clock and updates every reference cycle. A fine path takes the 1-bit early/late sign from the bang-bang phase detector. It runs a proportional-integral filter whose gains are powers of two, and the result drives the fine thermometer-coded capacitor bank of the oscillator.

A second path helps the loop acquire lock. It reads a five-level time-error code from a coarse detector that has a dead zone. While the code sits at its centre level, or while the path is disabled, the path does nothing: the coarse bank holds its integral value and the fractional divider word passes through unchanged. Outside the dead zone, only the sign of the code is used. That sign steps a higher-gain PI filter on the coarse thermometer bank. In the same cycle it adds or subtracts a step to the fractional divider word, which pulls the time error back toward zero. The path needs no table or state machine, and in steady state it is idle, so the fine loop behaves as if the path were absent.

A synchronous relock input loads both integrators with programmable start values. All outputs are registered and change only at the clock edge.

Top module: `lock_aid_loop_ctrl`

## Requirements
- R1: An asynchronous active-low reset sets the fine word to 2^(FW-1), the coarse word to 2^(CW-1) and the fractional output to zero.
- R2: When relock_i is high at a clock edge, both fine registers take fine_init_i, both coarse registers take coarse_init_i and frac_o takes frac_base_i. This overrides all other updates.
- R3: Otherwise, at each edge the fine integral changes by +2^alpha_sh_i when bbpd_sign_i is 1, or by -2^alpha_sh_i when it is 0. The result is clamped to [0, 2^FW-1].
- R4: The fine word is the new integral plus 2^beta_sh_i (sign 1) or minus 2^beta_sh_i (sign 0), clamped to [0, 2^FW-1]. It appears on the outputs after that edge.
- R5: The coarse code is decoded as follows. Value 2 is the dead zone. Values 0 and 1 mean a negative error. Values 3 to 7 mean a positive error.
- R6: While the coarse code is 2, the coarse integral holds, the coarse word equals the coarse integral, and frac_o equals frac_base_i.
- R7: When the aid path is active, the coarse integral changes by ±alpha1_i and the coarse word is that integral ±beta1_i. The + sign is used for a positive error. Both values are clamped to [0, 2^CW-1].
- R8: When the aid path is active, frac_o becomes frac_base_i plus lambda1_i for a positive error, or minus lambda1_i for a negative error. The result is clamped to [0, 2^KW-1] and registered.
- R9: Bit i of each thermometer output is 1 exactly when its binary word is greater than i.
- R10: When aid_en_i is low, the aid path behaves as in R6 whatever the coarse code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| relock_i | input | 1 | Synchronous load of initial integrator values |
| bbpd_sign_i | input | 1 | Bang-bang sign: 1 = +1, 0 = -1 |
| coarse_code_i | input | 3 | Coarse time-error code, 2 = dead zone |
| aid_en_i | input | 1 | Enable for the aid path |
| alpha_sh_i | input | SW | Fine integral gain, log2 |
| beta_sh_i | input | SW | Fine proportional gain, log2 |
| alpha1_i | input | CW | Coarse integral step |
| beta1_i | input | CW | Coarse proportional step |
| lambda1_i | input | KW | Feed-forward fractional step |
| frac_base_i | input | KW | Base fractional divider word |
| fine_init_i | input | FW | Fine integrator start value |
| coarse_init_i | input | CW | Coarse integrator start value |
| fine_therm_o | output | 2^FW-1 | Fine bank thermometer code |
| coarse_therm_o | output | 2^CW-1 | Coarse bank thermometer code |
| frac_o | output | KW | Corrected fractional divider word |

## Verification
The assertions check rules that hold on every cycle. After relock, the integrators carry the start values. The fine word lies on the side of the fine integral that the sign selects. An idle aid path freezes the coarse integral and passes the base word through. An active path never moves the coarse integral or the fractional word against the error. Every thermometer output has exactly as many ones as its word. The exact arithmetic can only be shown by the bench scenarios: the power-of-two step sizes, clamping at both ends of each range, the decode of every code value, the disable input, and relock winning over an active aid path.

// File: rtl/lock_aid_pkg.sv
package lock_aid_pkg;
  typedef enum logic [1:0] {
    AID_IDLE = 2'b00,
    AID_UP   = 2'b01,
    AID_DN   = 2'b10
  } aid_dir_e;

  localparam logic [2:0] DZ_CODE = 3'd2;

  function automatic aid_dir_e decode_aid(input logic en, input logic [2:0] code);
    if (!en || code == DZ_CODE) return AID_IDLE;
    else if (code > DZ_CODE)    return AID_UP;
    else                        return AID_DN;
  endfunction
endpackage

// File: rtl/la_fine_pi.sv
module la_fine_pi #(
  parameter int FW = 6,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          relock_i,
  input  logic [FW-1:0] init_i,
  input  logic          sign_i,
  input  logic [SW-1:0] alpha_sh_i,
  input  logic [SW-1:0] beta_sh_i,
  output logic [FW-1:0] word_o
);
  localparam int EW = FW + 2**SW + 2;
  localparam logic signed [EW-1:0] MAXV = EW'((2**FW) - 1);
  localparam logic [FW-1:0] RST_VAL = FW'(2**(FW-1));

  logic [FW-1:0] int_q, word_q, int_d, word_d;
  logic signed [EW-1:0] a_step, b_step, int_sum, word_sum;

  function automatic logic [FW-1:0] clamp(input logic signed [EW-1:0] v);
    if (v < 0)         return '0;
    else if (v > MAXV) return MAXV[FW-1:0];
    else               return v[FW-1:0];
  endfunction

  always_comb begin
    a_step   = EW'(1) << alpha_sh_i;
    b_step   = EW'(1) << beta_sh_i;
    int_sum  = sign_i ? $signed(EW'(int_q)) + a_step : $signed(EW'(int_q)) - a_step;
    int_d    = clamp(int_sum);
    word_sum = sign_i ? $signed(EW'(int_d)) + b_step : $signed(EW'(int_d)) - b_step;
    word_d   = clamp(word_sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= RST_VAL;
      word_q <= RST_VAL;
    end else if (relock_i) begin
      int_q  <= init_i;
      word_q <= init_i;
    end else begin
      int_q  <= int_d;
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

  p_fine_relock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> (int_q == $past(init_i)));
  p_fine_up_side_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!relock_i && sign_i) |=> (word_q >= int_q));
  p_fine_dn_side_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!relock_i && !sign_i) |=> (word_q <= int_q));
endmodule

// File: rtl/la_aid_pi.sv
module la_aid_pi
  import lock_aid_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          relock_i,
  input  logic [CW-1:0] init_i,
  input  aid_dir_e      dir_i,
  input  logic [CW-1:0] alpha1_i,
  input  logic [CW-1:0] beta1_i,
  output logic [CW-1:0] word_o
);
  localparam int EW = CW + 2;
  localparam logic signed [EW-1:0] MAXV = EW'((2**CW) - 1);
  localparam logic [CW-1:0] RST_VAL = CW'(2**(CW-1));

  logic [CW-1:0] int_q, word_q, int_d, word_d;
  logic signed [EW-1:0] int_sum, word_sum;

  function automatic logic [CW-1:0] clamp(input logic signed [EW-1:0] v);
    if (v < 0)         return '0;
    else if (v > MAXV) return MAXV[CW-1:0];
    else               return v[CW-1:0];
  endfunction

  always_comb begin
    int_sum  = $signed(EW'(int_q));
    word_sum = '0;
    int_d    = int_q;
    word_d   = int_q;
    if (dir_i != AID_IDLE) begin
      int_sum  = (dir_i == AID_UP) ? $signed(EW'(int_q)) + $signed(EW'(alpha1_i))
                                   : $signed(EW'(int_q)) - $signed(EW'(alpha1_i));
      int_d    = clamp(int_sum);
      word_sum = (dir_i == AID_UP) ? $signed(EW'(int_d)) + $signed(EW'(beta1_i))
                                   : $signed(EW'(int_d)) - $signed(EW'(beta1_i));
      word_d   = clamp(word_sum);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q  <= RST_VAL;
      word_q <= RST_VAL;
    end else if (relock_i) begin
      int_q  <= init_i;
      word_q <= init_i;
    end else begin
      int_q  <= int_d;
      word_q <= word_d;
    end
  end

  assign word_o = word_q;

  p_aid_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == AID_IDLE && !relock_i) |=> ($stable(int_q) && word_q == int_q));
  p_aid_up_nodec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == AID_UP && !relock_i) |=> (int_q >= $past(int_q)));
  p_aid_dn_noinc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == AID_DN && !relock_i) |=> (int_q <= $past(int_q)));
endmodule

// File: rtl/la_frac_ff.sv
module la_frac_ff
  import lock_aid_pkg::*;
#(
  parameter int KW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          relock_i,
  input  aid_dir_e      dir_i,
  input  logic [KW-1:0] base_i,
  input  logic [KW-1:0] lambda1_i,
  output logic [KW-1:0] frac_o
);
  localparam int EW = KW + 2;
  localparam logic signed [EW-1:0] MAXV = EW'((2**KW) - 1);

  logic [KW-1:0] frac_q, frac_d;
  logic signed [EW-1:0] sum;

  always_comb begin
    sum = $signed(EW'(base_i));
    if (!relock_i && dir_i == AID_UP)      sum = sum + $signed(EW'(lambda1_i));
    else if (!relock_i && dir_i == AID_DN) sum = sum - $signed(EW'(lambda1_i));
    if (sum < 0)         frac_d = '0;
    else if (sum > MAXV) frac_d = MAXV[KW-1:0];
    else                 frac_d = sum[KW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frac_q <= '0;
    else         frac_q <= frac_d;
  end

  assign frac_o = frac_q;

  p_frac_idle_base_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == AID_IDLE || relock_i) |=> (frac_q == $past(base_i)));
  p_frac_up_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == AID_UP && !relock_i) |=> (frac_q >= $past(base_i)));
  p_frac_dn_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == AID_DN && !relock_i) |=> (frac_q <= $past(base_i)));
endmodule

// File: rtl/la_therm.sv
module la_therm #(
  parameter int W = 4
) (
  input  logic [W-1:0]      bin_i,
  output logic [2**W-2:0]   therm_o
);
  localparam int N = 2**W - 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign therm_o[g] = (32'(bin_i) > g);
  end

  always_comb begin
    if (!$isunknown(bin_i))
      p_therm_count_r9: assert ($countones(therm_o) == 32'(bin_i));
  end
endmodule

// File: rtl/lock_aid_loop_ctrl.sv
module lock_aid_loop_ctrl
  import lock_aid_pkg::*;
#(
  parameter int FW = 6,
  parameter int CW = 4,
  parameter int KW = 8,
  parameter int SW = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             relock_i,
  input  logic             bbpd_sign_i,
  input  logic [2:0]       coarse_code_i,
  input  logic             aid_en_i,
  input  logic [SW-1:0]    alpha_sh_i,
  input  logic [SW-1:0]    beta_sh_i,
  input  logic [CW-1:0]    alpha1_i,
  input  logic [CW-1:0]    beta1_i,
  input  logic [KW-1:0]    lambda1_i,
  input  logic [KW-1:0]    frac_base_i,
  input  logic [FW-1:0]    fine_init_i,
  input  logic [CW-1:0]    coarse_init_i,
  output logic [2**FW-2:0] fine_therm_o,
  output logic [2**CW-2:0] coarse_therm_o,
  output logic [KW-1:0]    frac_o
);
  aid_dir_e      aid_dir;
  logic [FW-1:0] fine_word;
  logic [CW-1:0] coarse_word;

  assign aid_dir = decode_aid(aid_en_i, coarse_code_i);

  la_fine_pi #(.FW(FW), .SW(SW)) i_fine (
    .clk_i, .rst_ni, .relock_i,
    .init_i     (fine_init_i),
    .sign_i     (bbpd_sign_i),
    .alpha_sh_i (alpha_sh_i),
    .beta_sh_i  (beta_sh_i),
    .word_o     (fine_word)
  );

  la_aid_pi #(.CW(CW)) i_aid (
    .clk_i, .rst_ni, .relock_i,
    .init_i   (coarse_init_i),
    .dir_i    (aid_dir),
    .alpha1_i (alpha1_i),
    .beta1_i  (beta1_i),
    .word_o   (coarse_word)
  );

  la_frac_ff #(.KW(KW)) i_frac (
    .clk_i, .rst_ni, .relock_i,
    .dir_i     (aid_dir),
    .base_i    (frac_base_i),
    .lambda1_i (lambda1_i),
    .frac_o    (frac_o)
  );

  la_therm #(.W(FW)) i_fine_therm   (.bin_i(fine_word),   .therm_o(fine_therm_o));
  la_therm #(.W(CW)) i_coarse_therm (.bin_i(coarse_word), .therm_o(coarse_therm_o));

  p_dz_no_frac_move_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aid_en_i && !relock_i) |=> (frac_o == $past(frac_base_i)));
endmodule

// File: tb/test_lock_aid_loop_ctrl.sv
module test_lock_aid_loop_ctrl;
  localparam int FW = 6, CW = 4, KW = 8, SW = 3;
  localparam int FMAX = 2**FW - 1, CMAX = 2**CW - 1, KMAX = 2**KW - 1;

  logic clk = 1'b0, rst_n;
  logic relock, bbpd_sign, aid_en;
  logic [2:0] coarse_code;
  logic [SW-1:0] alpha_sh, beta_sh;
  logic [CW-1:0] alpha1, beta1, coarse_init;
  logic [KW-1:0] lambda1, frac_base;
  logic [FW-1:0] fine_init;
  logic [2**FW-2:0] fine_therm;
  logic [2**CW-2:0] coarse_therm;
  logic [KW-1:0] frac;

  always #(2.5ns) clk = ~clk;

  lock_aid_loop_ctrl #(.FW(FW), .CW(CW), .KW(KW), .SW(SW)) i_lock_aid_loop_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .relock_i(relock), .bbpd_sign_i(bbpd_sign),
    .coarse_code_i(coarse_code), .aid_en_i(aid_en), .alpha_sh_i(alpha_sh),
    .beta_sh_i(beta_sh), .alpha1_i(alpha1), .beta1_i(beta1), .lambda1_i(lambda1),
    .frac_base_i(frac_base), .fine_init_i(fine_init), .coarse_init_i(coarse_init),
    .fine_therm_o(fine_therm), .coarse_therm_o(coarse_therm), .frac_o(frac)
  );

  typedef struct { int fine; int coarse; int frac; string tag; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int mf_int, mf_word, mc_int, mc_word;
  bit done = 0;

  function automatic int clamp(input int v, input int mx);
    return (v < 0) ? 0 : ((v > mx) ? mx : v);
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic step(input logic s, input logic [2:0] code, input logic en,
                      input logic rl, input string tag);
    exp_t e;
    int dir, sg;
    bbpd_sign = s; coarse_code = code; aid_en = en; relock = rl;
    sg = s ? 1 : -1;
    if (rl) begin
      mf_int = int'(fine_init); mf_word = mf_int;
      mc_int = int'(coarse_init); mc_word = mc_int;
      e.frac = int'(frac_base);
    end else begin
      mf_int  = clamp(mf_int + sg * (1 << alpha_sh), FMAX);
      mf_word = clamp(mf_int + sg * (1 << beta_sh), FMAX);
      dir = (!en || code == 3'd2) ? 0 : ((code > 3'd2) ? 1 : -1);
      if (dir == 0) begin
        mc_word = mc_int;
        e.frac  = int'(frac_base);
      end else begin
        mc_int  = clamp(mc_int + dir * int'(alpha1), CMAX);
        mc_word = clamp(mc_int + dir * int'(beta1), CMAX);
        e.frac  = clamp(int'(frac_base) + dir * int'(lambda1), KMAX);
      end
    end
    e.fine = mf_word; e.coarse = mc_word; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(2ns);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " fine word"}, $countones(fine_therm), e.fine);
        chk({e.tag, " coarse word"}, $countones(coarse_therm), e.coarse);
        chk({e.tag, " frac"}, int'(frac), e.frac);
        chk("R9 fine thermometer shape",
            int'(fine_therm == (2**FW-1)'((64'(1) << e.fine) - 1)), 1);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(100us);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; relock = 1'b0; bbpd_sign = 1'b0; coarse_code = 3'd2; aid_en = 1'b1;
    alpha_sh = 3'd0; beta_sh = 3'd1; alpha1 = 4'd1; beta1 = 4'd2;
    lambda1 = 8'd20; frac_base = 8'd100; fine_init = 6'd10; coarse_init = 4'd3;
    #(12ns);
    chk("R1 reset fine", $countones(fine_therm), 2**(FW-1));
    chk("R1 reset coarse", $countones(coarse_therm), 2**(CW-1));
    chk("R1 reset frac", int'(frac), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mf_int = 2**(FW-1); mc_int = 2**(CW-1);

    step(1, 3'd2, 1, 1, "R2 relock");
    for (int i = 0; i < 4; i++) step(1, 3'd2, 1, 0, "R3 fine up, R6 dead zone");
    for (int i = 0; i < 4; i++) step(i[0], 3'd2, 1, 0, "R4 fine alternate");
    step(0, 3'd2, 1, 0, "R4 fine down");
    for (int i = 0; i < 3; i++) step(1, 3'd4, 1, 0, "R7 aid up");
    step(1, 3'd3, 1, 0, "R5 code 3 positive");
    step(0, 3'd7, 1, 0, "R5 code 7 positive");
    for (int i = 0; i < 3; i++) step(0, 3'd0, 1, 0, "R7 aid down");
    step(1, 3'd1, 1, 0, "R5 code 1 negative");
    step(1, 3'd4, 0, 0, "R10 aid disabled");
    step(0, 3'd0, 0, 0, "R10 aid disabled neg");
    alpha1 = 4'd5; beta1 = 4'd7;
    for (int i = 0; i < 4; i++) step(1, 3'd4, 1, 0, "R7 coarse clamp high");
    for (int i = 0; i < 5; i++) step(0, 3'd0, 1, 0, "R7 coarse clamp low");
    frac_base = 8'd250;
    step(1, 3'd4, 1, 0, "R8 frac clamp high");
    frac_base = 8'd5;
    step(1, 3'd0, 1, 0, "R8 frac clamp low");
    frac_base = 8'd100;
    step(1, 3'd4, 1, 0, "R8 frac add");
    step(1, 3'd2, 1, 0, "R6 frac back to base");
    alpha_sh = 3'd4; beta_sh = 3'd5;
    for (int i = 0; i < 6; i++) step(1, 3'd2, 1, 0, "R3 fine clamp high");
    for (int i = 0; i < 8; i++) step(0, 3'd2, 1, 0, "R3 fine clamp low");
    fine_init = 6'd40; coarse_init = 4'd12;
    step(1, 3'd4, 1, 1, "R2 relock priority");
    alpha_sh = 3'd1; beta_sh = 3'd0;
    step(1, 3'd2, 1, 0, "R4 after relock");
    @(negedge clk);
    @(negedge clk);
    summary();
  end
endmodule